// File: doc/BRIEF.md
# DRAM Page-Extension Address and Refresh Controller

This block lets a host whose memory controller only produces an 8-bit multiplexed DRAM address use a larger DRAM module. The host keeps driving the low eight DRAM address lines directly. This block drives the module's extra upper address lines and passes through, or rewrites, the three DRAM strobes (RAS, CAS and WE). The host has no signal that says whether a row or a column address is on the bus. The block therefore decides what to drive on the upper lines purely from the present levels of the RAS and CAS it sends to the DRAM. Because the DRAM needs no setup time but does need hold time, the upper-line value changes only as a direct result of a strobe edge.

The column value of the upper lines comes from a small bank register that the CPU writes at one decoded bus address. The selected bank replaces the lower half of the CPU address space, and only for CPU cycles. Video fetches, accesses to the upper half and row phases all see bank zero. After reset the register holds zero, so the machine starts with its standard memory map.

The host refreshes with RAS-only cycles, and it keeps CAS high during them. A refresh slot is recognised when the CPU clock phase E and the active-low horizontal sync are both low. Inside such a slot the block turns the refresh into a CAS-before-RAS cycle. The host's RAS is sent out as the DRAM CAS. The DRAM RAS is generated afterwards from the quadrature clock Q.

Top module: `dram_pext_top`

## Requirements
- R1: After reset the bank register is zero: a CPU access to the lower half with CAS low drives 0 on the upper lines.
- R2: When the DRAM RAS and CAS outputs are both high, the upper-line enable is low and the upper-line data is 0.
- R3: With DRAM RAS low and DRAM CAS high, the upper lines are enabled and carry the row value, which is all zeros.
- R4: With DRAM CAS low, whatever the DRAM RAS level, the upper lines are enabled and carry the column value.
- R5: The column value is the bank register when E is high and CPU address bit 15 is 0. Otherwise it is 0.
- R6: The bank register loads CPU data bits [3:0] on a falling edge of E, but only when R/W is low (write) and the CPU address equals PAGE_ADDR (default 16'hFFE8). The new value is visible from the next clock. Reads and writes to other addresses leave it unchanged.
- R7: Outside refresh slots (E high or hsN high), DRAM RAS, CAS and WE equal the host RAS, CAS and WE.
- R8: Inside a refresh slot (E low and hsN low), DRAM CAS equals host RAS. DRAM RAS is low only when host RAS is low and Q is high. DRAM WE is held high.
- R9: Inside a refresh slot, DRAM RAS is never low while DRAM CAS is high, which gives a CAS-before-RAS ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than E |
| rstN | input | 1 | Active-low asynchronous reset |
| e | input | 1 | CPU clock phase E |
| q | input | 1 | CPU quadrature clock Q |
| hsN | input | 1 | Horizontal sync, active low |
| rwN | input | 1 | CPU read (1) / write (0) |
| cpuAddr | input | 16 | CPU address bus |
| cpuData | input | 8 | CPU data bus |
| hostRasN | input | 1 | RAS from host memory controller |
| hostCasN | input | 1 | CAS from host memory controller |
| hostWeN | input | 1 | WE from host memory controller |
| dramRasN | output | 1 | RAS to DRAM module |
| dramCasN | output | 1 | CAS to DRAM module |
| dramWeN | output | 1 | WE to DRAM module |
| dramAddrHi | output | 4 | Upper DRAM address lines |
| dramAddrHiOe | output | 1 | Drive enable for upper lines (low = high impedance) |

## Verification
A bank register that holds the wrong value stays hidden until the next CPU column access to the lower half. It then shows up on the upper lines as soon as CAS falls. The bench therefore follows every write or ignored write with exactly that access. Errors in the strobe steering or in refresh recognition are combinational. They appear on the DRAM strobe and enable ports in the same instant that the inputs change. So every combination of strobe levels, E, Q, sync and address bit 15 is swept for each of the sixteen bank values.

// File: rtl/dram_pext_pkg.sv
package dram_pext_pkg;
  typedef struct packed {
    logic refreshSlot;
    logic rowSel;
    logic colSel;
    logic inBank;
    logic latchWr;
  } pext_strobe_t;
endpackage

// File: rtl/dram_pext_ctrl.sv
module dram_pext_ctrl
  import dram_pext_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 16'hFFE8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              e,
  input  logic              q,
  input  logic              hsN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              hostRasN,
  input  logic              hostCasN,
  input  logic              hostWeN,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output pext_strobe_t      strb
);
  localparam int BANK_BIT = ADDR_W - 1;

  logic eQ;
  logic refreshSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eQ <= 1'b0;
    else       eQ <= e;
  end

  assign refreshSlot = !e && !hsN;

  always_comb begin
    if (refreshSlot) begin
      dramCasN = hostRasN;
      dramRasN = hostRasN | !q;
      dramWeN  = 1'b1;
    end else begin
      dramCasN = hostCasN;
      dramRasN = hostRasN;
      dramWeN  = hostWeN;
    end
  end

  always_comb begin
    strb.refreshSlot = refreshSlot;
    strb.rowSel      = !dramRasN && dramCasN;
    strb.colSel      = !dramCasN;
    strb.inBank      = e && !cpuAddr[BANK_BIT];
    strb.latchWr     = eQ && !e && !rwN && (cpuAddr == PAGE_ADDR);
  end

  // R9
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!e && !hsN && !dramRasN) |-> !dramCasN);
  // R8
  refresh_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!e && !hsN) |-> (dramWeN && dramCasN == hostRasN));
  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (e || hsN) |-> (dramRasN == hostRasN && dramCasN == hostCasN && dramWeN == hostWeN));
endmodule

// File: rtl/dram_pext_dp.sv
module dram_pext_dp
  import dram_pext_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EXT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pext_strobe_t      strb,
  input  logic [DATA_W-1:0] cpuData,
  output logic [EXT_W-1:0]  addrHi,
  output logic              addrHiOe
);
  logic [EXT_W-1:0] pageQ;
  logic [EXT_W-1:0] colBits;
  logic [EXT_W-1:0] rowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pageQ <= '0;
    else if (strb.latchWr) pageQ <= cpuData[EXT_W-1:0];
  end

  assign colBits = strb.inBank ? pageQ : '0;
  assign rowBits = '0;

  always_comb begin
    addrHiOe = strb.rowSel || strb.colSel;
    if (strb.colSel)      addrHi = colBits;
    else if (strb.rowSel) addrHi = rowBits;
    else                  addrHi = '0;
  end

  // R6
  page_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchWr |=> (pageQ == $past(cpuData[EXT_W-1:0])));
  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchWr |=> $stable(pageQ));
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrHiOe |-> (addrHi == '0));
endmodule

// File: rtl/dram_pext_top.sv
module dram_pext_top
  import dram_pext_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int EXT_W  = 4,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 16'hFFE8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              e,
  input  logic              q,
  input  logic              hsN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              hostRasN,
  input  logic              hostCasN,
  input  logic              hostWeN,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic [EXT_W-1:0]  dramAddrHi,
  output logic              dramAddrHiOe
);
  pext_strobe_t strb;

  dram_pext_ctrl #(.ADDR_W(ADDR_W), .PAGE_ADDR(PAGE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .e(e), .q(q), .hsN(hsN), .rwN(rwN),
    .cpuAddr(cpuAddr), .hostRasN(hostRasN), .hostCasN(hostCasN),
    .hostWeN(hostWeN), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .strb(strb)
  );

  dram_pext_dp #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuData(cpuData),
    .addrHi(dramAddrHi), .addrHiOe(dramAddrHiOe)
  );

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dramRasN && dramCasN) |-> !dramAddrHiOe);
  // R3
  row_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dramRasN && dramCasN) |-> (dramAddrHiOe && dramAddrHi == '0));
  // R4
  col_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> dramAddrHiOe);
endmodule

// File: tb/dram_pext_top_bench.sv
module dram_pext_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic e = 1'b0, q = 1'b0, hsN = 1'b1, rwN = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic hostRasN = 1'b1, hostCasN = 1'b1, hostWeN = 1'b1;
  logic dramRasN, dramCasN, dramWeN, dramAddrHiOe;
  logic [3:0] dramAddrHi;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dram_pext_top u_dram_pext_top (
    .clk(clk), .rstN(rstN), .e(e), .q(q), .hsN(hsN), .rwN(rwN),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .hostRasN(hostRasN),
    .hostCasN(hostCasN), .hostWeN(hostWeN), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramWeN(dramWeN), .dramAddrHi(dramAddrHi),
    .dramAddrHiOe(dramAddrHiOe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d, input logic rw);
    @(negedge clk);
    hsN = 1'b1; e = 1'b1; cpuAddr = a; cpuData = d; rwN = rw;
    @(negedge clk);
    e = 1'b0;
    @(negedge clk);
    rwN = 1'b1; cpuAddr = '0;
  endtask

  task automatic readBank(input string tag, input int exp);
    @(negedge clk);
    hsN = 1'b1; e = 1'b1; cpuAddr = 16'h1234; hostRasN = 1'b0; hostCasN = 1'b0;
    #1;
    check(tag, dramAddrHi, exp);
    hostRasN = 1'b1; hostCasN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: bank zero after reset
    readBank("R1 reset bank", 0);
    // R6: read and miss-address writes ignored
    busWrite(16'hFFE8, 8'h07, 1'b1);
    readBank("R6 read ignored", 0);
    busWrite(16'hFFE9, 8'h05, 1'b0);
    readBank("R6 other addr ignored", 0);
    busWrite(16'hFFE8, 8'hA9, 1'b0);
    readBank("R6 load low nibble", 9);

    for (int pg = 0; pg < 16; pg++) begin
      busWrite(16'hFFE8, 8'(pg | 8'hF0), 1'b0);
      for (int v = 0; v < 64; v++) begin
        logic hr, hc, hw, ee, qq, hs, a15;
        logic refr, xr, xc, xw, xoe;
        int xa;
        hr = v[0]; hc = v[1]; hw = v[2]; ee = v[3]; qq = v[4]; hs = v[5];
        for (int b = 0; b < 2; b++) begin
          a15 = b[0];
          @(negedge clk);
          hostRasN = hr; hostCasN = hc; hostWeN = hw; e = ee; q = qq; hsN = hs;
          cpuAddr = {a15, 15'h0042};
          #1;
          refr = !ee && !hs;
          xc = refr ? hr : hc;
          xr = refr ? (hr | !qq) : hr;
          xw = refr ? 1'b1 : hw;
          xoe = !(xr && xc);
          xa = (!xc && ee && !a15) ? pg : 0;
          if (refr) begin
            check("R8 refresh cas", dramCasN, xc);
            check("R8 refresh ras", dramRasN, xr);
            check("R8 refresh we", dramWeN, 1);
            // R9: no RAS-low while CAS high
            check("R9 cbr order", int'(!dramRasN && dramCasN), 0);
          end else begin
            check("R7 pass ras", dramRasN, xr);
            check("R7 pass cas", dramCasN, xc);
            check("R7 pass we", dramWeN, xw);
          end
          if (xr && xc) begin
            check("R2 release oe", dramAddrHiOe, 0);
            check("R2 release data", dramAddrHi, 0);
          end else if (xc) begin
            check("R3 row oe", dramAddrHiOe, 1);
            check("R3 row zero", dramAddrHi, 0);
          end else begin
            check("R4 col oe", dramAddrHiOe, int'(xoe));
            check("R5 col value", dramAddrHi, xa);
          end
        end
      end
      hostRasN = 1'b1; hostCasN = 1'b1; hostWeN = 1'b1;
    end

    // R6: write of zero returns the standard map
    busWrite(16'hFFE8, 8'h00, 1'b0);
    readBank("R6 clear bank", 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule